// File: doc/BRIEF.md
# SD Command Response Error Checker

This block watches a single command/response exchange on the SD CMD line and raises sticky error flags when it goes wrong. While the host is sending a command, the block compares each bit the host drives as 1 with the line level sampled at the following SDCLK-enabled cycle. A mismatch means another device is pulling the line low. When that happens the block pulses an abort that tells the driver to let go of CMD, and it sets the timeout flag and the CRC flag together, so software can tell this case apart from an ordinary response failure.

After the command's last bit, the block counts SDCLK-enabled cycles while it waits for the response start bit, which is a 0 on the line. If no start bit appears within the window, the timeout flag is set. When a response is decoded, its end bit, CRC verdict and index field are checked. The CRC7 generator and the response shift register sit outside this block. They supply the decoded fields and a CRC-ok verdict.

Every flag stays set until software writes a 1 to its clear bit. A new command is started with `cmd_start`, and `cmd_end` marks the end of its last bit.

Top module: `sd_cmd_err_chk`

## Requirements
- R1: After reset, all four error flags and `cmd_abort` are 0.
- R2: After an accepted `cmd_end`, the block counts only cycles with `sdclk_en` high.
  - If `cmd_in` is 1 on TO_CYCLES (64) such samples in a row, `err_timeout` is set.
  - A 0 on `cmd_in` at or before that sample is taken as the start bit, and no timeout is flagged.
  - Cycles with `sdclk_en` low are not counted.
- R3: While a command is being sent, suppose one enabled sample has `cmd_oe`=1 with `cmd_out`=1, and the next enabled sample reads `cmd_in`=0.
  - `cmd_abort` goes high for one cycle.
  - `err_timeout` and `err_crc` are both set on that same edge, without waiting for the timeout window.
  - If the host drove 0, or had `cmd_oe` low, no conflict is flagged.
- R4: A response with `rsp_crc_ok`=0 sets `err_crc` only when `err_timeout` is 0 at that time.
- R5: A response with `rsp_end_bit`=0 sets `err_endbit`.
- R6: When `rsp_has_index`=1, a response whose `rsp_index` differs from `exp_index` sets `err_index`. When `rsp_has_index`=0, the index comparison is skipped.
- R7: Each `err_clr` bit clears only its own flag on the next edge: bit 0 clears timeout, bit 1 clears CRC, bit 2 clears end-bit and bit 3 clears index.
- R8: After an abort, a timeout or a checked response, the block is idle until the next `cmd_start`. While idle, `cmd_end`, the CMD line and the response inputs set no flag and raise no abort.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sdclk_en | input | 1 | One-cycle strobe marking an SDCLK sampling edge |
| cmd_start | input | 1 | Pulse: host begins sending a new command |
| cmd_end | input | 1 | Pulse: the command end bit has been sent |
| cmd_oe | input | 1 | Host output enable for the CMD line |
| cmd_out | input | 1 | Bit the host drives on CMD |
| cmd_in | input | 1 | Sampled CMD line level |
| exp_index | input | IDX_W | Index of the command that was sent |
| rsp_has_index | input | 1 | The response type carries a command index field |
| rsp_valid | input | 1 | Pulse: decoded response fields are valid |
| rsp_index | input | IDX_W | Index field of the received response |
| rsp_end_bit | input | 1 | Received end-bit value |
| rsp_crc_ok | input | 1 | The external CRC7 check passed |
| err_clr | input | 4 | Write-one-to-clear strobes, one bit per flag |
| err_timeout | output | 1 | Sticky response timeout / conflict flag |
| err_crc | output | 1 | Sticky CRC / conflict flag |
| err_endbit | output | 1 | Sticky end-bit error flag |
| err_index | output | 1 | Sticky index mismatch flag |
| cmd_abort | output | 1 | One-cycle pulse telling the driver to release CMD |

## Verification
The hardest case to reach is a start bit that arrives on exactly the last enabled sample of the timeout window, as opposed to one sample later. The stimulus sweeps the start-bit position across the whole window, from the first enabled sample to one past the end. It also varies the idle cycles between SDCLK strobes, so the bench shows that only enabled cycles are counted. A second near-exhaustive case is the conflict detector: every combination of output enable, driven bit and sampled line on the first enabled sample is applied, followed by a low line on the next enabled sample.

// File: rtl/sdrsp_pkg.sv
package sdrsp_pkg;
   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_DRIVE = 2'd1,
      PH_WAIT  = 2'd2,
      PH_RECV  = 2'd3
   } phase_t;

   // flag positions inside the sticky vector and the clear strobe
   localparam int FLG_TO  = 0;
   localparam int FLG_CRC = 1;
   localparam int FLG_END = 2;
   localparam int FLG_IDX = 3;
   localparam int FLG_N   = 4;
endpackage

// File: rtl/sdrsp_conflict.sv
module sdrsp_conflict (
   input  logic clk,
   input  logic rst_n,
   input  logic active,
   input  logic sdclk_en,
   input  logic drv_en,
   input  logic drv_bit,
   input  logic line,
   output logic conflict
);
   // remembers that the previous enabled sample had the host driving a 1
   logic drove_one;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         drove_one <= 1'b0;
      else if (!active)
         drove_one <= 1'b0;
      else if (sdclk_en)
         drove_one <= drv_en & drv_bit;
   end

   assign conflict = active & sdclk_en & drove_one & ~line;

   // R3
   no_conflict_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !active |=> !drove_one);
endmodule

// File: rtl/sdrsp_timer.sv
module sdrsp_timer #(
   parameter int TO_CYCLES = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  logic run,
   input  logic sdclk_en,
   input  logic line,
   output logic start_seen,
   output logic expired
);
   localparam int CW = $clog2(TO_CYCLES + 1);

   if (TO_CYCLES < 2) begin : g_bad_window
      $error("sdrsp_timer: TO_CYCLES must be at least 2");
   end

   logic [CW-1:0] cnt;
   logic          high_tick;

   assign high_tick  = run & sdclk_en & line;
   assign start_seen = run & sdclk_en & ~line;
   assign expired    = high_tick & (cnt == CW'(TO_CYCLES - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (load)
         cnt <= '0;
      else if (high_tick)
         cnt <= cnt + 1'b1;
   end

   // R2
   cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (cnt < CW'(TO_CYCLES)));

   // R2
   hold_when_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!sdclk_en && !load) |=> $stable(cnt));
endmodule

// File: rtl/sdrsp_fields.sv
module sdrsp_fields #(
   parameter int IDX_W       = 6,
   parameter bit INDEX_CHECK = 1'b1
) (
   input  logic             check,
   input  logic             end_bit,
   input  logic             crc_ok,
   input  logic             has_index,
   input  logic [IDX_W-1:0] got_index,
   input  logic [IDX_W-1:0] want_index,
   output logic             bad_end,
   output logic             bad_crc,
   output logic             bad_idx
);
   assign bad_end = check & ~end_bit;
   assign bad_crc = check & ~crc_ok;

   if (INDEX_CHECK) begin : g_idx_on
      assign bad_idx = check & has_index & (got_index != want_index);
   end else begin : g_idx_off
      logic unused_idx;
      assign unused_idx = ^{has_index, got_index, want_index};
      assign bad_idx    = 1'b0;
   end
endmodule

// File: rtl/sd_cmd_err_chk.sv
module sd_cmd_err_chk
   import sdrsp_pkg::*;
#(
   parameter int TO_CYCLES   = 64,
   parameter int IDX_W       = 6,
   parameter bit INDEX_CHECK = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sdclk_en,
   input  logic             cmd_start,
   input  logic             cmd_end,
   input  logic             cmd_oe,
   input  logic             cmd_out,
   input  logic             cmd_in,
   input  logic [IDX_W-1:0] exp_index,
   input  logic             rsp_has_index,
   input  logic             rsp_valid,
   input  logic [IDX_W-1:0] rsp_index,
   input  logic             rsp_end_bit,
   input  logic             rsp_crc_ok,
   input  logic [3:0]       err_clr,
   output logic             err_timeout,
   output logic             err_crc,
   output logic             err_endbit,
   output logic             err_index,
   output logic             cmd_abort
);
   if (IDX_W < 1 || IDX_W > 8) begin : g_bad_idx_w
      $error("sd_cmd_err_chk: IDX_W must lie in 1..8");
   end

   phase_t           phase, phase_nx;
   logic             conflict, start_seen, expired;
   logic             bad_end, bad_crc, bad_idx;
   logic             in_drive, in_wait, rsp_take, load_timer;
   logic [FLG_N-1:0] flags, flag_set;

   assign in_drive   = (phase == PH_DRIVE);
   assign in_wait    = (phase == PH_WAIT);
   assign rsp_take   = rsp_valid & (phase == PH_RECV);
   assign load_timer = in_drive & cmd_end;

   sdrsp_conflict u_conflict (
      .clk      (clk),
      .rst_n    (rst_n),
      .active   (in_drive),
      .sdclk_en (sdclk_en),
      .drv_en   (cmd_oe),
      .drv_bit  (cmd_out),
      .line     (cmd_in),
      .conflict (conflict)
   );

   sdrsp_timer #(.TO_CYCLES(TO_CYCLES)) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (load_timer),
      .run        (in_wait),
      .sdclk_en   (sdclk_en),
      .line       (cmd_in),
      .start_seen (start_seen),
      .expired    (expired)
   );

   sdrsp_fields #(.IDX_W(IDX_W), .INDEX_CHECK(INDEX_CHECK)) u_fields (
      .check      (rsp_take),
      .end_bit    (rsp_end_bit),
      .crc_ok     (rsp_crc_ok),
      .has_index  (rsp_has_index),
      .got_index  (rsp_index),
      .want_index (exp_index),
      .bad_end    (bad_end),
      .bad_crc    (bad_crc),
      .bad_idx    (bad_idx)
   );

   always_comb begin
      phase_nx = phase;
      if (cmd_start) begin
         phase_nx = PH_DRIVE;
      end else begin
         unique case (phase)
            PH_DRIVE: if (conflict)        phase_nx = PH_IDLE;
                      else if (cmd_end)    phase_nx = PH_WAIT;
            PH_WAIT:  if (start_seen)      phase_nx = PH_RECV;
                      else if (expired)    phase_nx = PH_IDLE;
            PH_RECV:  if (rsp_valid)       phase_nx = PH_IDLE;
            default:                       phase_nx = PH_IDLE;
         endcase
      end
   end

   always_comb begin
      flag_set          = '0;
      flag_set[FLG_TO]  = conflict | expired;
      flag_set[FLG_CRC] = conflict | (bad_crc & ~flags[FLG_TO]);
      flag_set[FLG_END] = bad_end;
      flag_set[FLG_IDX] = bad_idx;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase     <= PH_IDLE;
         flags     <= '0;
         cmd_abort <= 1'b0;
      end else begin
         phase     <= phase_nx;
         flags     <= (flags & ~err_clr) | flag_set;
         cmd_abort <= conflict;
      end
   end

   assign err_timeout = flags[FLG_TO];
   assign err_crc     = flags[FLG_CRC];
   assign err_endbit  = flags[FLG_END];
   assign err_index   = flags[FLG_IDX];

   // R3
   conflict_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_abort |-> (err_timeout && err_crc));

   // R4
   crc_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (err_timeout && !err_crc && phase != PH_DRIVE) |=> !err_crc);

   // R6
   index_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!err_index && !(rsp_valid && rsp_has_index)) |=> !err_index);

   // R7
   clr_endbit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (err_clr[FLG_END] && !rsp_valid) |=> !err_endbit);

   // R8
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_IDLE && !cmd_start) |=> !cmd_abort);
endmodule

// File: tb/test_sd_cmd_err_chk.sv
module test_sd_cmd_err_chk;
   localparam int TO_CYCLES = 64;
   localparam int IDX_W     = 6;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             sdclk_en = 1'b0, cmd_start = 1'b0, cmd_end = 1'b0;
   logic             cmd_oe = 1'b0, cmd_out = 1'b0, cmd_in = 1'b1;
   logic [IDX_W-1:0] exp_index = 6'h11, rsp_index = 6'h11;
   logic             rsp_has_index = 1'b1, rsp_valid = 1'b0;
   logic             rsp_end_bit = 1'b1, rsp_crc_ok = 1'b1;
   logic [3:0]       err_clr = 4'h0;
   logic             err_timeout, err_crc, err_endbit, err_index, cmd_abort;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   sd_cmd_err_chk #(.TO_CYCLES(TO_CYCLES), .IDX_W(IDX_W)) i_sd_cmd_err_chk (
      .clk(clk), .rst_n(rst_n), .sdclk_en(sdclk_en), .cmd_start(cmd_start),
      .cmd_end(cmd_end), .cmd_oe(cmd_oe), .cmd_out(cmd_out), .cmd_in(cmd_in),
      .exp_index(exp_index), .rsp_has_index(rsp_has_index), .rsp_valid(rsp_valid),
      .rsp_index(rsp_index), .rsp_end_bit(rsp_end_bit), .rsp_crc_ok(rsp_crc_ok),
      .err_clr(err_clr), .err_timeout(err_timeout), .err_crc(err_crc),
      .err_endbit(err_endbit), .err_index(err_index), .cmd_abort(cmd_abort)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic cyc();
      @(negedge clk);
   endtask

   task automatic clear_all();
      err_clr = 4'hF; cyc(); err_clr = 4'h0;
   endtask

   task automatic start_cmd();
      cmd_start = 1'b1; cyc(); cmd_start = 1'b0;
   endtask

   task automatic end_cmd();
      cmd_end = 1'b1; cyc(); cmd_end = 1'b0;
   endtask

   // one enabled SDCLK sample followed by gap disabled cycles
   task automatic sample(input logic lvl, input int gap);
      sdclk_en = 1'b1; cmd_in = lvl; cyc();
      sdclk_en = 1'b0; cmd_in = 1'b1;
      for (int g = 0; g < gap; g++) cyc();
   endtask

   task automatic respond(input logic eb, input logic ok, input logic hi, input logic match);
      rsp_end_bit = eb; rsp_crc_ok = ok; rsp_has_index = hi;
      rsp_index = match ? exp_index : (exp_index ^ 6'h05);
      rsp_valid = 1'b1; cyc(); rsp_valid = 1'b0;
      rsp_end_bit = 1'b1; rsp_crc_ok = 1'b1; rsp_index = exp_index;
      cyc();
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : main
      repeat (3) cyc();
      rst_n = 1'b1;
      cyc();
      // R1 reset state
      chk("R1 timeout", err_timeout, 0);
      chk("R1 crc", err_crc, 0);
      chk("R1 endbit", err_endbit, 0);
      chk("R1 index", err_index, 0);
      chk("R1 abort", cmd_abort, 0);

      // R2 sweep start-bit position 1..TO_CYCLES+1, varying SDCLK gaps
      for (int k = 1; k <= TO_CYCLES + 1; k++) begin
         clear_all();
         start_cmd();
         end_cmd();
         for (int j = 1; j < k && j <= TO_CYCLES; j++) sample(1'b1, 1 + (k % 3));
         if (k == TO_CYCLES) chk("R2 no timeout before window end", err_timeout, 0);
         if (k <= TO_CYCLES) begin
            sample(1'b0, 1);
            respond(1'b1, 1'b1, 1'b1, 1'b1);
         end
         chk($sformatf("R2 timeout start-bit at %0d", k), err_timeout, (k > TO_CYCLES) ? 1 : 0);
      end

      // R4 CRC failure while the timeout flag is still set leaves err_crc at 0
      start_cmd(); end_cmd(); sample(1'b0, 1);
      respond(1'b1, 1'b0, 1'b1, 1'b1);
      chk("R4 crc masked by timeout", err_crc, 0);
      chk("R4 timeout kept", err_timeout, 1);

      // R5 R6 R4 exhaustive response field combinations
      for (int c = 0; c < 16; c++) begin
         clear_all();
         start_cmd(); end_cmd();
         sample(1'b1, 2); sample(1'b0, 1);
         respond(c[0], c[1], c[2], c[3]);
         chk($sformatf("R5 endbit combo %0d", c), err_endbit, c[0] ? 0 : 1);
         chk($sformatf("R4 crc combo %0d", c), err_crc, c[1] ? 0 : 1);
         chk($sformatf("R6 index combo %0d", c), err_index, (c[2] && !c[3]) ? 1 : 0);
         chk($sformatf("R2 no timeout combo %0d", c), err_timeout, 0);
      end

      // R3 conflict sweep over oe/bit/line on the first sample, line low on the next
      for (int c = 0; c < 8; c++) begin
         clear_all();
         start_cmd();
         cmd_oe = c[0]; cmd_out = c[1];
         sample(c[2], 1);
         sdclk_en = 1'b1; cmd_in = 1'b0; cyc();
         sdclk_en = 1'b0; cmd_in = 1'b1;
         chk($sformatf("R3 abort combo %0d", c), cmd_abort, (c[0] && c[1]) ? 1 : 0);
         chk($sformatf("R3 timeout combo %0d", c), err_timeout, (c[0] && c[1]) ? 1 : 0);
         chk($sformatf("R3 crc combo %0d", c), err_crc, (c[0] && c[1]) ? 1 : 0);
         cyc();
         chk($sformatf("R3 abort one cycle combo %0d", c), cmd_abort, 0);
         cmd_oe = 1'b0; cmd_out = 1'b0;
      end

      // R7 selective clear; flags currently hold timeout and crc from the last conflict
      err_clr = 4'b0001; cyc(); err_clr = 4'h0;
      chk("R7 timeout cleared", err_timeout, 0);
      chk("R7 crc kept", err_crc, 1);
      err_clr = 4'b0010; cyc(); err_clr = 4'h0;
      chk("R7 crc cleared", err_crc, 0);

      // R8 idle after the abort: nothing is checked until cmd_start
      cmd_oe = 1'b1; cmd_out = 1'b1;
      sample(1'b1, 1); sample(1'b0, 1);
      cmd_oe = 1'b0; cmd_out = 1'b0;
      chk("R8 no abort while idle", cmd_abort, 0);
      respond(1'b0, 1'b0, 1'b1, 1'b0);
      end_cmd();
      for (int j = 0; j < TO_CYCLES + 4; j++) sample(1'b1, 0);
      chk("R8 timeout idle", err_timeout, 0);
      chk("R8 crc idle", err_crc, 0);
      chk("R8 endbit idle", err_endbit, 0);
      chk("R8 index idle", err_index, 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule